// File: doc/BRIEF.md
# Dual-Edge Pin Capture with System-Clock Resynchronization

This block is the receive register stage for one data pin. It works in one of two modes. In single-rate mode the pin is sampled on every rising edge of the system clock and shown on one output word. In dual-rate mode a source-synchronous strobe samples the pin twice per strobe period. The value taken on the strobe's rising edge and the value taken on its falling edge form two separate streams. Both streams then pass through a two-register resynchronization pipeline in the system clock domain before they reach the core.

The resynchronization pipeline can be clocked on either edge of the system clock. Integration picks the edge that gives the strobe-captured data the most setup margin for the strobe phase seen on the board. The pin first passes through a delay-path selector. In this model both branches of that selector are pass-throughs, so the selector changes no timing.

Top module: `ddr_in_capture`

## Requirements
- R1: With `ddr_mode` = 0 (single-rate) and `ce` = 1, each rising edge of `clk` loads `pin` into `sdr_data`, so the new value is visible one cycle after it was sampled.
- R2: With `ddr_mode` = 1 (dual-rate), the pin value sampled on a rising strobe edge appears on `rise_data`.
- R3: With `ddr_mode` = 1, the pin value sampled on the following falling strobe edge appears on `fall_data`, together with the rising-edge sample of the same strobe period.
- R4: With `resync_inv` = 0, the resynchronization registers clock on rising `clk` edges. A sample pair that is complete before `clk` edge n is presented on the outputs after edge n+1, which is two resync edges.
- R5: With `resync_inv` = 1, the resynchronization registers clock on falling `clk` edges and keep the same two-edge latency. `resync_inv` is static outside reset.
- R6: `rst_n` is active low and synchronous to each register's own clock, and it overrides `ce`. While it is asserted, `sdr_data`, `rise_data` and `fall_data` clear to 0.
- R7: With `ce` = 0, every register holds its value, so all three outputs stay unchanged while the pin and the strobe keep moving.
- R8: In single-rate mode, `rise_data` and `fall_data` keep their last values.
- R9: In dual-rate mode, `sdr_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Clock enable for every register of the stage |
| ddr_mode | input | 1 | 0 = single-rate capture, 1 = dual-rate strobe capture |
| resync_inv | input | 1 | 1 = resync registers use the falling edge of `clk` |
| strobe | input | 1 | Source-synchronous capture strobe |
| pin | input | W | Pin data |
| sdr_data | output | W | Single-rate captured word |
| rise_data | output | W | Rising-strobe-edge stream in the system domain |
| fall_data | output | W | Falling-strobe-edge stream in the system domain |

## Verification
The bench drives the strobe at two different phases against `clk`: a quarter period late with rising-edge resync, and three quarters late with falling-edge resync. Each phase is checked against its expected pipeline index. A design that resynced on the wrong edge, or that swapped the rising and falling streams, would shift or mispair the words. Directed all-ones and all-zeros pairs in opposite streams expose bit or stream crossover. Holds are checked at the outputs under `ce` low, in the idle mode, and under reset with `ce` low. A design that ignored the enable, ran both paths at once, or let the enable beat the reset would show changed or non-zero words.

// File: rtl/ddr_in_pkg.sv
// Shared types for the dual-edge pin capture stage.
// Assumes: nothing beyond IEEE 1800-2017.
package ddr_in_pkg;

    // capture mode as driven on ddr_mode
    typedef enum logic {
        CAP_SDR = 1'b0,
        CAP_DDR = 1'b1
    } cap_mode_e;

    // resync clock edge as driven on resync_inv
    typedef enum logic {
        RS_RISE = 1'b0,
        RS_FALL = 1'b1
    } rs_edge_e;

    // number of resync stages the latency is specified for
    localparam int unsigned RESYNC_DEPTH_NOM = 2;

endpackage

// File: rtl/in_delay_path.sv
// Input delay selector. USE_DELAY picks the delayed branch or the bypass
// branch. The analog delay is modelled as a pass-through, so both variants
// have zero delay in simulation.
// Assumes: W >= 1.
module in_delay_path #(
    parameter int unsigned W         = 4,
    parameter bit          USE_DELAY = 1'b1
) (
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] path_o
);

    generate
        if (USE_DELAY) begin : g_delayed
            logic [W-1:0] dly_model;
            // delay element modelled as a wire
            assign dly_model = pin_i;
            assign path_o    = dly_model;
        end else begin : g_bypass
            // direct route to capture registers
            assign path_o = pin_i;
        end
    endgenerate

endmodule

// File: rtl/sdr_capture.sv
// Single-rate capture register on the rising edge of the system clock.
// Loads only while enabled and in single-rate mode; otherwise holds.
// Assumes: rst_n synchronous to clk.
module sdr_capture #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic         sdr_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    // capture register with reset priority over enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ce && sdr_en) begin
            q <= din;
        end
    end

    AST_SDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && sdr_en) |=> (q == $past(din)));                     // R1
    AST_SDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce || !sdr_en) |=> $stable(q));                          // R9
    AST_SDR_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (q == '0));                                     // R6

endmodule

// File: rtl/strobe_capture.sv
// Dual-edge strobe capture: one register on each strobe edge.
// Assumes: ddr_en and ce are quasi-static relative to the strobe;
// rst_n is honoured only on strobe edges.
module strobe_capture #(
    parameter int unsigned W = 4
) (
    input  logic         strobe,
    input  logic         rst_n,
    input  logic         ce,
    input  logic         ddr_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] q_rise,
    output logic [W-1:0] q_fall
);

    // rising-edge sample of the pin
    always_ff @(posedge strobe) begin
        if (!rst_n) begin
            q_rise <= '0;
        end else if (ce && ddr_en) begin
            q_rise <= din;
        end
    end

    // falling-edge sample of the pin
    always_ff @(negedge strobe) begin
        if (!rst_n) begin
            q_fall <= '0;
        end else if (ce && ddr_en) begin
            q_fall <= din;
        end
    end

    AST_RISE_LOAD: assert property (@(posedge strobe) disable iff (!rst_n)
        (ce && ddr_en) |=> (q_rise == $past(din)));                // R2
    AST_FALL_LOAD: assert property (@(negedge strobe) disable iff (!rst_n)
        (ce && ddr_en) |=> (q_fall == $past(din)));                // R3
    AST_RISE_HOLD: assert property (@(posedge strobe) disable iff (!rst_n)
        (!ce || !ddr_en) |=> $stable(q_rise));                     // R7

endmodule

// File: rtl/resync_stage.sv
// Moves the two strobe-domain streams into the system domain through a
// STAGES-deep register pipeline clocked on the edge chosen by resync_inv.
// Assumes: resync_inv changes only during reset; STAGES >= 1.
module resync_stage #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         resync_inv,
    input  logic         rst_n,
    input  logic         ce,
    input  logic         ddr_en,
    input  logic [W-1:0] in_rise,
    input  logic [W-1:0] in_fall,
    output logic [W-1:0] out_rise,
    output logic [W-1:0] out_fall
);

    localparam int unsigned LAST = STAGES - 1;

    logic                      rclk;
    logic [STAGES-1:0][W-1:0] rise_pipe;
    logic [STAGES-1:0][W-1:0] fall_pipe;

    // resync clock: system clock or its inverse
    assign rclk = clk ^ resync_inv;

    // shift both streams together through the pipeline
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rise_pipe <= '0;
            fall_pipe <= '0;
        end else if (ce && ddr_en) begin
            for (int s = 0; s < int'(STAGES); s++) begin
                if (s == 0) begin
                    rise_pipe[s] <= in_rise;
                    fall_pipe[s] <= in_fall;
                end else begin
                    rise_pipe[s] <= rise_pipe[s-1];
                    fall_pipe[s] <= fall_pipe[s-1];
                end
            end
        end
    end

    assign out_rise = rise_pipe[LAST];
    assign out_fall = fall_pipe[LAST];

    AST_RS_CLEAR: assert property (@(posedge rclk)
        !rst_n |=> (out_rise == '0 && out_fall == '0));            // R6
    AST_RS_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
        (!ce || !ddr_en) |=> ($stable(out_rise) && $stable(out_fall))); // R8
    AST_RS_FIRST: assert property (@(posedge rclk) disable iff (!rst_n)
        (ce && ddr_en) |=> (rise_pipe[0] == $past(in_rise)));      // R4

endmodule

// File: rtl/ddr_in_capture.sv
// Top of the pin capture stage: delay selector, single-rate register,
// dual-edge strobe capture and system-domain resync pipeline.
// Assumes: ddr_mode and resync_inv are static while data flows.
module ddr_in_capture
    import ddr_in_pkg::*;
#(
    parameter int unsigned W             = 4,
    parameter bit          USE_DELAY     = 1'b1,
    parameter int unsigned RESYNC_STAGES = RESYNC_DEPTH_NOM
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic         ddr_mode,
    input  logic         resync_inv,
    input  logic         strobe,
    input  logic [W-1:0] pin,
    output logic [W-1:0] sdr_data,
    output logic [W-1:0] rise_data,
    output logic [W-1:0] fall_data
);

    cap_mode_e    mode;
    logic         sdr_en;
    logic         ddr_en;
    logic [W-1:0] path;
    logic [W-1:0] cap_rise;
    logic [W-1:0] cap_fall;

    // decode the mode select
    assign mode   = cap_mode_e'(ddr_mode);
    assign sdr_en = (mode == CAP_SDR);
    assign ddr_en = (mode == CAP_DDR);

    in_delay_path #(.W(W), .USE_DELAY(USE_DELAY)) u_dly (
        .pin_i  (pin),
        .path_o (path)
    );

    sdr_capture #(.W(W)) u_sdr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce     (ce),
        .sdr_en (sdr_en),
        .din    (path),
        .q      (sdr_data)
    );

    strobe_capture #(.W(W)) u_cap (
        .strobe (strobe),
        .rst_n  (rst_n),
        .ce     (ce),
        .ddr_en (ddr_en),
        .din    (path),
        .q_rise (cap_rise),
        .q_fall (cap_fall)
    );

    resync_stage #(.W(W), .STAGES(RESYNC_STAGES)) u_rs (
        .clk        (clk),
        .resync_inv (resync_inv),
        .rst_n      (rst_n),
        .ce         (ce),
        .ddr_en     (ddr_en),
        .in_rise    (cap_rise),
        .in_fall    (cap_fall),
        .out_rise   (rise_data),
        .out_fall   (fall_data)
    );

endmodule

// File: tb/test_ddr_in_capture.sv
`timescale 1ns / 100ps
module test_ddr_in_capture;

    localparam int W = 4;
    localparam int NB = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ce = 1'b1;
    logic         ddr_mode = 1'b0;
    logic         resync_inv = 1'b0;
    logic         strobe = 1'b0;
    logic [W-1:0] pin = '0;
    logic [W-1:0] sdr_data, rise_data, fall_data;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] pa [NB];
    logic [W-1:0] pb [NB];

    ddr_in_capture #(.W(W)) i_ddr_in_capture (
        .clk(clk), .rst_n(rst_n), .ce(ce), .ddr_mode(ddr_mode),
        .resync_inv(resync_inv), .strobe(strobe), .pin(pin),
        .sdr_data(sdr_data), .rise_data(rise_data), .fall_data(fall_data)
    );

    always #2 clk = ~clk;

    // pipeline index offset seen at posedge+1ns sampling for each resync edge
    function automatic int lat_of(input bit inv);
        return inv ? 3 : 2;
    endfunction

    // directed patterns first, then random words
    function automatic logic [W-1:0] pat(input int i, input bit second);
        if (i == 0) return second ? '0 : '1;
        if (i == 1) return second ? '1 : '0;
        return W'($urandom);
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic fill();
        for (int i = 0; i < NB; i++) begin
            pa[i] = pat(i, 1'b0);
            pb[i] = pat(i, 1'b1);
        end
    endtask

    // drive NB strobe periods of data and check both streams at fixed latency
    task automatic ddr_burst(input bit inv, input logic [W-1:0] sdr_hold);
        int lat;
        lat = lat_of(inv);
        @(posedge clk);
        fork
            begin
                if (inv) #2.5; else #0.5;
                for (int i = 0; i < NB; i++) begin
                    pin = pa[i];
                    #0.5 strobe = 1'b1;
                    #1.5 pin = pb[i];
                    #0.5 strobe = 1'b0;
                    #1.5;
                end
            end
            begin
                for (int m = 1; m < NB + lat; m++) begin
                    @(posedge clk);
                    #1;
                    if (m >= lat) begin
                        check(rise_data == pa[m-lat], inv ? "R5 R2 rise" : "R4 R2 rise",
                              rise_data, pa[m-lat]);
                        check(fall_data == pb[m-lat], inv ? "R5 R3 fall" : "R4 R3 fall",
                              fall_data, pb[m-lat]);
                    end
                    check(sdr_data == sdr_hold, "R9 sdr hold", sdr_data, sdr_hold);
                end
            end
        join
    endtask

    task automatic check_zero(input string req);
        check(sdr_data == '0, req, sdr_data, '0);
        check(rise_data == '0, req, rise_data, '0);
        check(fall_data == '0, req, fall_data, '0);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] prev, hs, hr, hf;
        void'($urandom(32'd20240611));
        // reset with strobe toggling so the strobe registers clear too
        for (int i = 0; i < 4; i++) begin
            #1 strobe = 1'b1;
            #1 strobe = 1'b0;
        end
        @(posedge clk); #1;
        check_zero("R6 reset");

        // single-rate random capture
        rst_n = 1'b1;
        prev = '0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            if (i > 0) check(sdr_data == prev, "R1 sdr load", sdr_data, prev);
            check(rise_data == '0 && fall_data == '0, "R8 ddr idle", rise_data, '0);
            prev = (i == 1) ? '1 : (i == 2) ? '0 : W'($urandom);
            pin  = prev;
        end
        @(posedge clk); #1;
        check(sdr_data == prev, "R1 sdr last", sdr_data, prev);

        // clock enable low in single-rate mode
        hs = sdr_data;
        ce = 1'b0;
        for (int i = 0; i < 5; i++) begin
            pin = W'($urandom) ^ hs ^ '1;
            @(posedge clk); #1;
            check(sdr_data == hs, "R7 sdr ce low", sdr_data, hs);
        end
        ce = 1'b1;

        // dual-rate, rising-edge resync
        ddr_mode = 1'b1;
        fill();
        ddr_burst(1'b0, hs);

        // clock enable low while strobe and pin move
        hr = rise_data; hf = fall_data;
        @(posedge clk); #1;
        ce = 1'b0;
        for (int i = 0; i < NB; i++) begin
            pa[i] = ~hr; pb[i] = ~hf;
        end
        fork
            ddr_burst_nocheck();
            for (int i = 0; i < 10; i++) begin
                @(posedge clk); #1;
                check(rise_data == hr, "R7 rise ce low", rise_data, hr);
                check(fall_data == hf, "R7 fall ce low", fall_data, hf);
            end
        join
        ce = 1'b1;

        // back to single-rate: strobe streams hold
        ddr_mode = 1'b0;
        for (int i = 0; i < 8; i++) begin
            pin = W'($urandom);
            prev = pin;
            #0.5 strobe = 1'b1;
            #1 strobe = 1'b0;
            @(posedge clk); #1;
            check(sdr_data == prev, "R1 sdr after ddr", sdr_data, prev);
            check(rise_data == hr, "R8 rise hold", rise_data, hr);
            check(fall_data == hf, "R8 fall hold", fall_data, hf);
        end

        // reset, switch to falling-edge resync
        rst_n = 1'b0;
        resync_inv = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check_zero("R6 reset inv");
        rst_n = 1'b1;
        ddr_mode = 1'b1;
        fill();
        ddr_burst(1'b1, '0);

        // reset wins over a low clock enable
        ce = 1'b0;
        rst_n = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        check_zero("R6 reset over ce");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // strobe burst without checks, aligned as for rising-edge resync
    task automatic ddr_burst_nocheck();
        for (int i = 0; i < 8; i++) begin
            pin = pa[i];
            #0.5 strobe = 1'b1;
            #1.5 pin = pb[i];
            #0.5 strobe = 1'b0;
            #1.5;
        end
    endtask

endmodule